// File: doc/BRIEF.md
# Lifting Wavelet Stage (Predict / Update / Scale)

This block performs one decomposition level of a lifting-scheme wavelet transform on a stream of signed 16-bit samples. The source presents the stream two samples at a time: the even-indexed sample on lane 0 and the following odd-indexed sample on lane 1. A predict step turns each odd sample into a detail value from its two even neighbours. An update step turns each even sample into an approximation value from the two nearest details. A scaling step then weights the approximation and the detail by separate programmable factors. One pair goes in and one (approximation, detail) pair comes out per clock, so a multi-level transform chains one copy per level and the cost per level stays fixed.

Frames are delimited by first and last flags on the input pair. At the edges of a frame the missing neighbour is replaced by its mirror, so no sample from another frame is used. With the `inverse` input high, the same three stages run in reverse order: scaling is applied first, then the update is taken back out, then the predict is undone. The lanes then carry (approximation, detail) in and (even, odd) out. When every scale factor is unity, forward followed by inverse gives back the original samples bit for bit. `inverse` and the coefficients may only change while no frame is inside the block.

Top module: `lift_wavelet_stage`

## Requirements
- R1: In forward mode, lane 0 carries sample 2n (even e[n]) and lane 1 carries sample 2n+1 (odd o[n]). The detail is d[n] = o[n] - T(p, e[n], e[n+1]), where T(c,a,b) = floor(c*(a+b)/1024) truncated to 16 bits. Every result wraps to 16-bit two's complement.
- R2: In forward mode the approximation before scaling is s[n] = e[n] + T(u, d[n-1], d[n]).
- R3: Forward outputs are out_lane0 = floor(scale_a*s[n]/1024) and out_lane1 = floor(scale_b*d[n]/1024), both wrapped to 16 bits. All coefficients are 12-bit signed with 10 fraction bits, so 1024 is unity.
- R4: Frame edges use symmetric extension. The last pair uses its own even sample as e[n+1], and the first pair uses d[0] as d[-1]. A one-pair frame uses both rules.
- R5: A pair is accepted on every cycle that in_valid is high, including a first pair that directly follows the last pair of another frame. Each accepted pair yields exactly one output pair, in order. out_first and out_last mark the first and last output of each frame.
- R6: A pair that is not the last of its frame gives no output until the next pair of its frame is accepted. The last pair's output emerges without any further input.
- R7: With inverse = 1 and both scale factors at 1024, feeding the forward outputs back on lanes 0 and 1 reproduces the original even and odd samples exactly.
- R8: In inverse mode s = floor(scale_a*A/1024) and d = floor(scale_b*D/1024). Then e[n] = s[n] - T(u, d[n-1], d[n]) and o[n] = d[n] + T(p, e[n], e[n+1]), with the same edge rules as R4.
- R9: out_valid is low during reset and stays low until an accepted pair has worked through the block. It is never high for a pair that was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inverse | input | 1 | 0 = forward decomposition, 1 = reconstruction |
| coef_p | input | 12 | Predict coefficient, signed, 10 fraction bits |
| coef_u | input | 12 | Update coefficient, signed, 10 fraction bits |
| scale_a | input | 12 | Scale factor for lane 0, signed, 10 fraction bits |
| scale_b | input | 12 | Scale factor for lane 1, signed, 10 fraction bits |
| in_valid | input | 1 | Input pair present |
| in_first | input | 1 | Input pair opens a frame |
| in_last | input | 1 | Input pair closes a frame |
| in_lane0 | input | 16 | Even sample (forward) or approximation (inverse) |
| in_lane1 | input | 16 | Odd sample (forward) or detail (inverse) |
| out_valid | output | 1 | Output pair present |
| out_first | output | 1 | Output pair opens a frame |
| out_last | output | 1 | Output pair closes a frame |
| out_lane0 | output | 16 | Approximation (forward) or even sample (inverse) |
| out_lane1 | output | 16 | Detail (forward) or odd sample (inverse) |

## Verification
The bench sweeps frame lengths from one to six pairs under four coefficient sets. It includes extreme coefficients and full-scale samples, so wrap-around and floor rounding of negative products are exercised. A design that took the wrong mirror at a frame edge would corrupt only the first or last output, and a one-pair frame catches a design that handles just one of the two edges. Back-to-back frames and a deliberate stall in the middle of a frame target a lookahead that drops, duplicates or releases a held pair too early, which would show up as a count or order mismatch. Round trips through both modes, and inverse runs with non-unity scale factors, expose any step applied in the wrong order or with the wrong sign.

// File: rtl/lws_pkg.sv
`timescale 1ns/1ps
package lws_pkg;
    localparam int DATA_W = 16;
    localparam int COEF_W = 12;
    localparam int FRAC_W = 10;
    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + COEF_W;
    localparam int MUL_W  = DATA_W + COEF_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    localparam coef_t UNITY = coef_t'(1 << FRAC_W);

    typedef struct packed {
        logic    valid;
        logic    first;
        logic    last;
        sample_t lane0;
        sample_t lane1;
    } pair_t;

    // floor(c * (a + b) / 2^FRAC_W), truncated to a sample
    function automatic sample_t lift_term(coef_t c, sample_t a, sample_t b);
        logic signed [SUM_W-1:0]  sum;
        logic signed [PROD_W-1:0] prod;
        sum  = SUM_W'(a) + SUM_W'(b);
        prod = PROD_W'(sum) * PROD_W'(c);
        prod = prod >>> FRAC_W;
        return prod[DATA_W-1:0];
    endfunction

    // floor(k * a / 2^FRAC_W), truncated to a sample
    function automatic sample_t scale_mul(coef_t k, sample_t a);
        logic signed [MUL_W-1:0] prod;
        prod = MUL_W'(a) * MUL_W'(k);
        prod = prod >>> FRAC_W;
        return prod[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/lws_ahead.sv
`timescale 1ns/1ps
// Lookahead lifting step: lane1 is corrected from lane0 of this pair and the next.
module lws_ahead
    import lws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  subtract,
    input  coef_t coef,
    input  pair_t in_p,
    output pair_t out_q
);
    pair_t   held;
    logic    fire;
    sample_t nxt;
    sample_t step;

    always_comb begin
        fire = held.valid && (in_p.valid || held.last);
        nxt  = held.last ? held.lane0 : in_p.lane0;
        step = lift_term(coef, held.lane0, nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            out_q <= '0;
        end else begin
            out_q.valid <= fire;
            out_q.first <= held.first;
            out_q.last  <= held.last;
            out_q.lane0 <= held.lane0;
            out_q.lane1 <= subtract ? held.lane1 - step : held.lane1 + step;
            if (in_p.valid)
                held <= in_p;
            else if (fire)
                held.valid <= 1'b0;
        end
    end

    // R6: a held last pair always leaves on the next edge
    a_r6_last_flushes: assert property (@(posedge clk) disable iff (rst)
        (held.valid && held.last) |=> out_q.valid);
    // R9: no output without a pair that completed its neighbourhood
    a_r9_no_spurious_ahead: assert property (@(posedge clk) disable iff (rst)
        !held.valid |=> !out_q.valid);
    // R1: lane 0 crosses this step untouched
    a_r1_lane0_kept: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_q.valid && out_q.lane0 == $past(held.lane0)));
endmodule

// File: rtl/lws_causal.sv
`timescale 1ns/1ps
// Causal lifting step: lane0 is corrected from lane1 of the previous pair and this one.
module lws_causal
    import lws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  subtract,
    input  coef_t coef,
    input  pair_t in_p,
    output pair_t out_q
);
    sample_t prev_l1;
    sample_t step;

    always_comb begin
        step = lift_term(coef, in_p.first ? in_p.lane1 : prev_l1, in_p.lane1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l1 <= '0;
            out_q   <= '0;
        end else begin
            out_q.valid <= in_p.valid;
            out_q.first <= in_p.first;
            out_q.last  <= in_p.last;
            out_q.lane1 <= in_p.lane1;
            out_q.lane0 <= subtract ? in_p.lane0 - step : in_p.lane0 + step;
            if (in_p.valid)
                prev_l1 <= in_p.lane1;
        end
    end

    // R2: lane 1 crosses this step untouched, one cycle later
    a_r2_lane1_kept: assert property (@(posedge clk) disable iff (rst)
        in_p.valid |=> (out_q.valid && out_q.lane1 == $past(in_p.lane1)));
    // R9: nothing leaves without something entering
    a_r9_no_spurious_causal: assert property (@(posedge clk) disable iff (rst)
        !in_p.valid |=> !out_q.valid);
endmodule

// File: rtl/lws_scale.sv
`timescale 1ns/1ps
// Per-lane fixed-point weighting.
module lws_scale
    import lws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  coef_t k0,
    input  coef_t k1,
    input  pair_t in_p,
    output pair_t out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_p.valid;
            out_q.first <= in_p.first;
            out_q.last  <= in_p.last;
            out_q.lane0 <= scale_mul(k0, in_p.lane0);
            out_q.lane1 <= scale_mul(k1, in_p.lane1);
        end
    end

    // R3: a unity factor passes the sample through unchanged
    a_r3_unity_scale: assert property (@(posedge clk) disable iff (rst)
        (in_p.valid && k0 == UNITY) |=> (out_q.lane0 == $past(in_p.lane0)));
endmodule

// File: rtl/lift_wavelet_stage.sv
`timescale 1ns/1ps
module lift_wavelet_stage (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               inverse,
    input  logic signed [lws_pkg::COEF_W-1:0]  coef_p,
    input  logic signed [lws_pkg::COEF_W-1:0]  coef_u,
    input  logic signed [lws_pkg::COEF_W-1:0]  scale_a,
    input  logic signed [lws_pkg::COEF_W-1:0]  scale_b,
    input  logic                               in_valid,
    input  logic                               in_first,
    input  logic                               in_last,
    input  logic signed [lws_pkg::DATA_W-1:0]  in_lane0,
    input  logic signed [lws_pkg::DATA_W-1:0]  in_lane1,
    output logic                               out_valid,
    output logic                               out_first,
    output logic                               out_last,
    output logic signed [lws_pkg::DATA_W-1:0]  out_lane0,
    output logic signed [lws_pkg::DATA_W-1:0]  out_lane1
);
    import lws_pkg::*;

    pair_t src;
    pair_t ahead_in, ahead_out;
    pair_t causal_in, causal_out;
    pair_t scale_in, scale_out;
    pair_t result;

    // forward: ahead -> causal -> scale ; inverse: scale -> causal -> ahead
    always_comb begin
        src       = '{valid: in_valid, first: in_first, last: in_last,
                      lane0: in_lane0, lane1: in_lane1};
        ahead_in  = inverse ? causal_out : src;
        causal_in = inverse ? scale_out  : ahead_out;
        scale_in  = inverse ? src        : causal_out;
        result    = inverse ? ahead_out  : scale_out;
    end

    lws_ahead u_ahead (
        .clk      (clk),
        .rst      (rst),
        .subtract (!inverse),
        .coef     (coef_p),
        .in_p     (ahead_in),
        .out_q    (ahead_out)
    );

    lws_causal u_causal (
        .clk      (clk),
        .rst      (rst),
        .subtract (inverse),
        .coef     (coef_u),
        .in_p     (causal_in),
        .out_q    (causal_out)
    );

    lws_scale u_scale (
        .clk   (clk),
        .rst   (rst),
        .k0    (scale_a),
        .k1    (scale_b),
        .in_p  (scale_in),
        .out_q (scale_out)
    );

    assign out_valid = result.valid;
    assign out_first = result.first;
    assign out_last  = result.last;
    assign out_lane0 = result.lane0;
    assign out_lane1 = result.lane1;
endmodule

// File: tb/lift_wavelet_stage_test.sv
`timescale 1ns/1ps
module lift_wavelet_stage_test;
    import lws_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic    rst, inverse;
    coef_t   coef_p, coef_u, scale_a, scale_b;
    logic    in_valid, in_first, in_last;
    sample_t in_lane0, in_lane1;
    logic    out_valid, out_first, out_last;
    sample_t out_lane0, out_lane1;

    lift_wavelet_stage uut (
        .clk(clk), .rst(rst), .inverse(inverse),
        .coef_p(coef_p), .coef_u(coef_u), .scale_a(scale_a), .scale_b(scale_b),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_lane0(in_lane0), .in_lane1(in_lane1),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
        .out_lane0(out_lane0), .out_lane1(out_lane1)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int unsigned seed = 32'h1234_5678;

    sample_t src0 [8];
    sample_t src1 [8];
    sample_t keep0 [8];
    sample_t keep1 [8];
    sample_t e0[$], e1[$], g0[$], g1[$];
    logic    ef[$], el[$], gf[$], gl[$];

    coef_t set_p [4] = '{12'sd512, 12'sd1600, -12'sd2048, 12'sd0};
    coef_t set_u [4] = '{12'sd256, -12'sd700, 12'sd2047, 12'sd0};
    coef_t set_a [4] = '{12'sd1024, 12'sd1448, 12'sd2047, 12'sd1024};
    coef_t set_b [4] = '{12'sd1024, 12'sd724, -12'sd2048, 12'sd1024};

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R5 watchdog expired: actual cycles=%0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            g0.push_back(out_lane0);
            g1.push_back(out_lane1);
            gf.push_back(out_first);
            gl.push_back(out_last);
        end
    end

    function automatic sample_t w(longint x);
        return x[DATA_W-1:0];
    endfunction

    function automatic sample_t bterm(coef_t c, sample_t a, sample_t b);
        longint t;
        t = (longint'(c) * (longint'(a) + longint'(b))) >>> FRAC_W;
        return w(t);
    endfunction

    function automatic sample_t bscale(coef_t k, sample_t a);
        longint t;
        t = (longint'(k) * longint'(a)) >>> FRAC_W;
        return w(t);
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // pattern 0: pseudo-random, 1: full-scale alternation
    task automatic fill(int pat);
        for (int i = 0; i < 8; i++) begin
            if (pat == 1) begin
                src0[i] = (i % 2 == 0) ? 16'sh7FFF : 16'sh8000;
                src1[i] = (i % 3 == 0) ? 16'sh8000 : 16'sh7FFF;
            end else begin
                int unsigned r;
                r = rnd();
                src0[i] = r[23:8];
                r = rnd();
                src1[i] = r[23:8];
            end
        end
    endtask

    task automatic push_exp(int n, sample_t a [8], sample_t b [8]);
        for (int i = 0; i < n; i++) begin
            e0.push_back(a[i]);
            e1.push_back(b[i]);
            ef.push_back(i == 0);
            el.push_back(i == n - 1);
        end
    endtask

    task automatic model_fwd(int n);
        sample_t d [8];
        sample_t a [8];
        sample_t b [8];
        sample_t s;
        for (int i = 0; i < n; i++) begin
            sample_t nx;
            nx   = (i == n - 1) ? src0[i] : src0[i + 1];
            d[i] = w(longint'(src1[i]) - longint'(bterm(coef_p, src0[i], nx)));
        end
        for (int i = 0; i < n; i++) begin
            s    = w(longint'(src0[i]) + longint'(bterm(coef_u, (i == 0) ? d[0] : d[i - 1], d[i])));
            a[i] = bscale(scale_a, s);
            b[i] = bscale(scale_b, d[i]);
        end
        push_exp(n, a, b);
    endtask

    task automatic model_inv(int n);
        sample_t s [8];
        sample_t d [8];
        sample_t ev [8];
        sample_t od [8];
        for (int i = 0; i < n; i++) begin
            s[i] = bscale(scale_a, src0[i]);
            d[i] = bscale(scale_b, src1[i]);
        end
        for (int i = 0; i < n; i++)
            ev[i] = w(longint'(s[i]) - longint'(bterm(coef_u, (i == 0) ? d[0] : d[i - 1], d[i])));
        for (int i = 0; i < n; i++)
            od[i] = w(longint'(d[i]) + longint'(bterm(coef_p, ev[i], (i == n - 1) ? ev[i] : ev[i + 1])));
        push_exp(n, ev, od);
    endtask

    task automatic drive_pair(sample_t l0, sample_t l1, logic f, logic l);
        @(negedge clk);
        in_valid = 1'b1; in_first = f; in_last = l;
        in_lane0 = l0;   in_lane1 = l1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        end
    endtask

    task automatic send_frame(int n, int gap);
        for (int i = 0; i < n; i++) begin
            drive_pair(src0[i], src1[i], i == 0, i == n - 1);
            if (gap != 0) idle(1);
        end
    endtask

    task automatic drain_check(string req);
        int m;
        idle(10);
        checks++;
        if (g0.size() != e0.size()) begin
            fails++;
            $display("FAIL %s output count: actual=%0d expected=%0d", req, g0.size(), e0.size());
        end
        m = (g0.size() < e0.size()) ? g0.size() : e0.size();
        for (int i = 0; i < m; i++) begin
            checks++;
            if (g0[i] !== e0[i] || g1[i] !== e1[i] || gf[i] !== ef[i] || gl[i] !== el[i]) begin
                fails++;
                $display("FAIL %s pair %0d: actual=(%0d,%0d,f%0b,l%0b) expected=(%0d,%0d,f%0b,l%0b)",
                         req, i, g0[i], g1[i], gf[i], gl[i], e0[i], e1[i], ef[i], el[i]);
            end
        end
        e0.delete(); e1.delete(); ef.delete(); el.delete();
        g0.delete(); g1.delete(); gf.delete(); gl.delete();
    endtask

    task automatic load_set(int k);
        coef_p = set_p[k]; coef_u = set_u[k];
        scale_a = set_a[k]; scale_b = set_b[k];
    endtask

    initial begin
        rst = 1'b1; inverse = 1'b0;
        coef_p = 12'sd512; coef_u = 12'sd256; scale_a = UNITY; scale_b = UNITY;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_lane0 = '0; in_lane1 = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: actual out_valid=%b expected=0", out_valid);
        end
        rst = 1'b0;
        idle(3);
        checks++;
        if (g0.size() != 0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 idle after reset: actual outputs=%0d expected=0", g0.size());
        end

        // R1 R2 R3 R4: forward sweep over coefficient sets, lengths and spacing
        for (int cs = 0; cs < 4; cs++) begin
            load_set(cs);
            for (int n = 1; n <= 6; n++) begin
                for (int gap = 0; gap < 2; gap++) begin
                    fill((n == 6 && gap == 1) ? 1 : 0);
                    model_fwd(n);
                    send_frame(n, gap);
                    drain_check("R1 R2 R3 R4 forward");
                end
            end
        end

        // R5: back-to-back frames with no idle cycle between them
        load_set(1);
        fill(0); model_fwd(3); send_frame(3, 0);
        fill(0); model_fwd(1); send_frame(1, 0);
        fill(0); model_fwd(4); send_frame(4, 0);
        drain_check("R5 back-to-back");

        // R6: a non-last pair is held until its neighbour arrives
        load_set(0);
        fill(0); model_fwd(3);
        drive_pair(src0[0], src1[0], 1'b1, 1'b0);
        idle(6);
        checks++;
        if (g0.size() != 0) begin
            fails++;
            $display("FAIL R6 stalled pair emitted: actual outputs=%0d expected=0", g0.size());
        end
        drive_pair(src0[1], src1[1], 1'b0, 1'b0);
        idle(4);
        checks++;
        if (g0.size() != 1) begin
            fails++;
            $display("FAIL R6 after neighbour: actual outputs=%0d expected=1", g0.size());
        end
        drive_pair(src0[2], src1[2], 1'b0, 1'b1);
        drain_check("R6 hold");

        // R7: forward then inverse with unity scaling recovers the input
        for (int cs = 0; cs < 4; cs++) begin
            for (int n = 1; n <= 6; n++) begin
                load_set(cs);
                scale_a = UNITY; scale_b = UNITY;
                inverse = 1'b0;
                fill((n == 5) ? 1 : 0);
                for (int i = 0; i < 8; i++) begin keep0[i] = src0[i]; keep1[i] = src1[i]; end
                send_frame(n, 0);
                idle(10);
                checks++;
                if (g0.size() != n) begin
                    fails++;
                    $display("FAIL R7 forward count: actual=%0d expected=%0d", g0.size(), n);
                end
                for (int i = 0; i < 8; i++) begin
                    src0[i] = (i < g0.size()) ? g0[i] : '0;
                    src1[i] = (i < g1.size()) ? g1[i] : '0;
                end
                g0.delete(); g1.delete(); gf.delete(); gl.delete();
                inverse = 1'b1;
                push_exp(n, keep0, keep1);
                send_frame(n, cs % 2);
                drain_check("R7 round trip");
            end
        end

        // R8: inverse arithmetic with non-unity scale factors
        inverse = 1'b1;
        for (int cs = 0; cs < 4; cs++) begin
            load_set(cs);
            for (int n = 1; n <= 6; n++) begin
                fill((n == 4) ? 1 : 0);
                model_inv(n);
                send_frame(n, n % 2);
                drain_check("R8 inverse");
            end
        end
        inverse = 1'b0;

        summary();
        $finish;
    end
endmodule